// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps the time of day and the calendar as a chain of packed BCD counters: hundredths of a second, seconds, minutes, hours (24-hour), day of week, day of month, month, a two-digit year and a century flag. An internal prescaler divides a free-running base tick enable into the hundredths step. Each counter carries into the next one when it passes its last value. The day-of-month limit follows the current month and the leap rule.

A host loads fields one at a time through a byte-wide write port with eight addresses. Every write resets the prescaler and the hundredths field, so the next seconds step falls exactly one second after the write. A stop flag, stored with the seconds, freezes the whole chain. A century-enable flag and a century flag are stored with the hours. The outputs are the live counter values and flags, meant to feed a separate register copy that the host can read.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the fields are hundredths 00, seconds 00, minutes 00, hours 00, day of week 1, date 01, month 01, year 00, and the stop, century-enable and century flags are all 0.
- R2: A write loads the field selected by `wr_addr_i`. The layout is: 1 = seconds in data[6:0] and stop in data[7]; 2 = minutes in data[6:0]; 3 = hours in data[5:0], century in data[6] and century-enable in data[7]; 4 = day of week in data[2:0]; 5 = date in data[5:0]; 6 = month in data[4:0]; 7 = year in data[7:0]. Bits outside these positions are discarded, and unused output bits read 0.
- R3: Every write, including a write to address 0, sets hundredths to 00 and clears the prescaler. A write to address 0 changes no other field or flag. A prescaler step that falls in the same cycle as a write is lost.
- R4: Hundredths advance by one in BCD for every DIV cycles in which `base_tick_i` is high. The first step comes on the DIV-th such cycle after a write. Cycles with `base_tick_i` low do not count.
- R5: Hundredths wrap from 99 to 00, seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00. Each wrap advances the next field by one.
- R6: Day of week advances together with the date and wraps from 7 to 1.
- R7: The date wraps to 01 after day 31 in months 01, 03, 05, 07, 08, 10 and 12, and after day 30 in months 04, 06, 09 and 11. In month 02 it wraps after day 29 when the BCD year is divisible by four, and after day 28 otherwise.
- R8: When the date wraps, the month advances, going from 12 back to 01. When the month goes from 12 to 01, the year advances, going from 99 back to 00.
- R9: When the year goes from 99 to 00, the century flag inverts if century-enable is 1 and keeps its value if century-enable is 0.
- R10: While stop is 1, no field and no prescaler state changes except through writes. When stop is cleared by a write, seconds advance exactly 100*DIV base ticks after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_tick_i | input | 1 | Base tick enable fed to the prescaler |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_addr_i | input | 3 | Field address of the write |
| wr_data_i | input | 8 | Write data |
| csec_o | output | 8 | Hundredths of a second, BCD |
| sec_o | output | 7 | Seconds, BCD |
| min_o | output | 7 | Minutes, BCD |
| hour_o | output | 6 | Hours, BCD, 24-hour |
| dow_o | output | 3 | Day of week, 1 to 7 |
| date_o | output | 6 | Day of month, BCD |
| month_o | output | 5 | Month, BCD |
| year_o | output | 8 | Year, BCD |
| stop_o | output | 1 | Stop flag |
| cent_en_o | output | 1 | Century-enable flag |
| cent_o | output | 1 | Century flag |

## Verification
The counter assertions assume that every value the host writes is valid BCD within the range of its field, and that a written date does not exceed the length of the month in force. Under that assumption a counter never holds a value beyond its wrap point, and the carry and hold properties apply. The bench writes only calendar-valid values. Its masking tests set only bits that fall outside the field width. It always writes the year and the month before the date, so each test starts from a coherent calendar.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned NUM_FIELDS = 8;

  typedef enum logic [2:0] {
    F_CSEC = 3'd0, F_SEC = 3'd1, F_MIN = 3'd2, F_HOUR = 3'd3,
    F_DOW = 3'd4, F_DATE = 3'd5, F_MONTH = 3'd6, F_YEAR = 3'd7
  } field_e;

  function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return {v[7:4], v[3:0] + 4'h1};
  endfunction

  function automatic logic leap_bcd(input logic [7:0] yr);
    if (!yr[4]) return (yr[3:0] == 4'h0) || (yr[3:0] == 4'h4) || (yr[3:0] == 4'h8);
    return (yr[3:0] == 4'h2) || (yr[3:0] == 4'h6);
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02: return leap_bcd(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] field_lo(input int i);
    return (i == int'(F_DOW) || i == int'(F_DATE) || i == int'(F_MONTH)) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic base_tick_i,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          step;

  assign step   = base_tick_i && run_i && !clr_i;
  assign tick_o = step && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R4
  AST_NO_TICK_AFTER_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !tick_o); // R3
endmodule

// File: rtl/bcd_field_ctr.sv
module bcd_field_ctr
  import cal_pkg::*;
#(
  parameter logic [7:0] LO = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  input  logic       inc_i,
  input  logic [7:0] hi_i,
  output logic [7:0] val_o,
  output logic       at_max_o
);
  logic [7:0] val_q;

  assign val_o    = val_q;
  assign at_max_o = (val_q == hi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= LO;
    else if (ld_i)   val_q <= ld_val_i;
    else if (inc_i)  val_q <= at_max_o ? LO : bcd_inc8(val_q);
  end

  AST_WRAP_TO_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && val_q == hi_i) |=> (val_o == LO)); // R5
  AST_BCD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && val_q != hi_i && val_q[3:0] != 4'h9) |=> (val_o == $past(val_q) + 8'h01)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !ld_i) |=> $stable(val_o)); // R10
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import cal_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       base_tick_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] csec_o,
  output logic [6:0] sec_o,
  output logic [6:0] min_o,
  output logic [5:0] hour_o,
  output logic [2:0] dow_o,
  output logic [5:0] date_o,
  output logic [4:0] month_o,
  output logic [7:0] year_o,
  output logic       stop_o,
  output logic       cent_en_o,
  output logic       cent_o
);
  localparam int unsigned NF = NUM_FIELDS;

  logic [7:0]    fld   [NF];
  logic [7:0]    hi    [NF];
  logic [7:0]    ldv   [NF];
  logic [NF-1:0] ld, inc, at_max;
  logic          tick;
  logic          stop_q, cent_en_q, cent_q;
  logic          wr_sec, wr_hour, year_wrap;

  assign wr_sec  = wr_en_i && (wr_addr_i == F_SEC);
  assign wr_hour = wr_en_i && (wr_addr_i == F_HOUR);

  cal_prescaler #(.DIV(DIV)) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .base_tick_i(base_tick_i),
    .run_i      (!stop_q),
    .clr_i      (wr_en_i),
    .tick_o     (tick)
  );

  always_comb begin
    hi[F_CSEC]  = 8'h99;
    hi[F_SEC]   = 8'h59;
    hi[F_MIN]   = 8'h59;
    hi[F_HOUR]  = 8'h23;
    hi[F_DOW]   = 8'h07;
    hi[F_DATE]  = month_days(fld[F_MONTH], fld[F_YEAR]);
    hi[F_MONTH] = 8'h12;
    hi[F_YEAR]  = 8'h99;
  end

  always_comb begin
    ldv[F_CSEC]  = 8'h00;
    ldv[F_SEC]   = {1'b0, wr_data_i[6:0]};
    ldv[F_MIN]   = {1'b0, wr_data_i[6:0]};
    ldv[F_HOUR]  = {2'b00, wr_data_i[5:0]};
    ldv[F_DOW]   = {5'b0, wr_data_i[2:0]};
    ldv[F_DATE]  = {2'b00, wr_data_i[5:0]};
    ldv[F_MONTH] = {3'b000, wr_data_i[4:0]};
    ldv[F_YEAR]  = wr_data_i;
    for (int i = 0; i < int'(NF); i++)
      ld[i] = wr_en_i && ((i == 0) || (wr_addr_i == 3'(i)));
  end

  // carry chain; dow and date share the hour carry
  always_comb begin
    inc          = '0;
    inc[F_CSEC]  = tick;
    inc[F_SEC]   = inc[F_CSEC] && at_max[F_CSEC];
    inc[F_MIN]   = inc[F_SEC]  && at_max[F_SEC];
    inc[F_HOUR]  = inc[F_MIN]  && at_max[F_MIN];
    inc[F_DOW]   = inc[F_HOUR] && at_max[F_HOUR];
    inc[F_DATE]  = inc[F_HOUR] && at_max[F_HOUR];
    inc[F_MONTH] = inc[F_DATE] && at_max[F_DATE];
    inc[F_YEAR]  = inc[F_MONTH] && at_max[F_MONTH];
  end

  assign year_wrap = inc[F_YEAR] && at_max[F_YEAR];

  for (genvar g = 0; g < int'(NF); g++) begin : g_field
    bcd_field_ctr #(.LO(field_lo(g))) u_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ld_i    (ld[g]),
      .ld_val_i(ldv[g]),
      .inc_i   (inc[g]),
      .hi_i    (hi[g]),
      .val_o   (fld[g]),
      .at_max_o(at_max[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q    <= 1'b0;
      cent_en_q <= 1'b0;
      cent_q    <= 1'b0;
    end else begin
      if (wr_sec) stop_q <= wr_data_i[7];
      if (wr_hour) begin
        cent_en_q <= wr_data_i[7];
        cent_q    <= wr_data_i[6];
      end else if (year_wrap && cent_en_q) begin
        cent_q <= ~cent_q;
      end
    end
  end

  assign csec_o    = fld[F_CSEC];
  assign sec_o     = fld[F_SEC][6:0];
  assign min_o     = fld[F_MIN][6:0];
  assign hour_o    = fld[F_HOUR][5:0];
  assign dow_o     = fld[F_DOW][2:0];
  assign date_o    = fld[F_DATE][5:0];
  assign month_o   = fld[F_MONTH][4:0];
  assign year_o    = fld[F_YEAR];
  assign stop_o    = stop_q;
  assign cent_en_o = cent_en_q;
  assign cent_o    = cent_q;

  AST_WR_CLEARS_CSEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (csec_o == 8'h00)); // R3
  AST_STOP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_q && !wr_en_i) |=> ($stable(csec_o) && $stable(sec_o))); // R10
  AST_CENT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cent_en_q && !wr_hour) |=> $stable(cent_o)); // R9
  AST_CENT_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cent_en_q && !wr_hour && year_wrap) |=> (cent_o != $past(cent_o))); // R9
  AST_DOW_WITH_DATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc[F_DATE] && !wr_en_i && dow_o == 3'd7) |=> (dow_o == 3'd1)); // R6
endmodule

// File: tb/bcd_calendar_clock_test.sv
module bcd_calendar_clock_test;
  localparam int unsigned DIV = 4;
  localparam int SEC_EDGES = 100 * DIV;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic base_tick_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] csec_o;
  logic [6:0] sec_o, min_o;
  logic [5:0] hour_o, date_o;
  logic [2:0] dow_o;
  logic [4:0] month_o;
  logic [7:0] year_o;
  logic stop_o, cent_en_o, cent_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  bcd_calendar_clock #(.DIV(DIV)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .base_tick_i(base_tick_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .csec_o(csec_o), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .dow_o(dow_o), .date_o(date_o), .month_o(month_o), .year_o(year_o),
    .stop_o(stop_o), .cent_en_o(cent_en_o), .cent_o(cent_o)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // order: year, month, date, dow, hour, min, sec (last write is the time reference)
  task automatic set_all(input logic [7:0] yr, mo, dt, dw, hr, mi, se);
    wr(3'd7, yr); wr(3'd6, mo); wr(3'd5, dt); wr(3'd4, dw);
    wr(3'd3, hr); wr(3'd2, mi); wr(3'd1, se);
  endtask

  task automatic t_reset;
    chk("R1", "csec", csec_o, 8'h00);
    chk("R1", "sec", {1'b0, sec_o}, 8'h00);
    chk("R1", "min", {1'b0, min_o}, 8'h00);
    chk("R1", "hour", {2'b0, hour_o}, 8'h00);
    chk("R1", "dow", {5'b0, dow_o}, 8'h01);
    chk("R1", "date", {2'b0, date_o}, 8'h01);
    chk("R1", "month", {3'b0, month_o}, 8'h01);
    chk("R1", "year", year_o, 8'h00);
    chk("R1", "flags", {5'b0, stop_o, cent_en_o, cent_o}, 8'h00);
  endtask

  task automatic t_write_fields;
    base_tick_i = 1'b0;
    wr(3'd7, 8'h47); wr(3'd6, 8'hE9); wr(3'd5, 8'hD5); wr(3'd4, 8'hF3);
    wr(3'd3, 8'h40 | 8'h17); wr(3'd2, 8'h38); wr(3'd1, 8'h42);
    chk("R2", "year", year_o, 8'h47);
    chk("R2", "month masked", {3'b0, month_o}, 8'h09);
    chk("R2", "date masked", {2'b0, date_o}, 8'h15);
    chk("R2", "dow masked", {5'b0, dow_o}, 8'h03);
    chk("R2", "hour", {2'b0, hour_o}, 8'h17);
    chk("R2", "cent flags", {6'b0, cent_en_o, cent_o}, 8'h01);
    chk("R2", "min", {1'b0, min_o}, 8'h38);
    chk("R2", "sec", {1'b0, sec_o}, 8'h42);
    chk("R2", "stop", {7'b0, stop_o}, 8'h00);
    // a write to 0 touches nothing but hundredths
    base_tick_i = 1'b1;
    edges(20);
    chk("R3", "csec before write", csec_o, 8'h05);
    wr(3'd0, 8'h55);
    chk("R3", "csec after addr0 write", csec_o, 8'h00);
    chk("R3", "sec after addr0 write", {1'b0, sec_o}, 8'h42);
    chk("R3", "min after addr0 write", {1'b0, min_o}, 8'h38);
    chk("R3", "cent flags after addr0 write", {6'b0, cent_en_o, cent_o}, 8'h01);
  endtask

  task automatic t_prescale;
    base_tick_i = 1'b1;
    wr(3'd2, 8'h10);
    edges(DIV - 1);
    chk("R4", "csec before first step", csec_o, 8'h00);
    edges(1);
    chk("R4", "csec first step", csec_o, 8'h01);
    base_tick_i = 1'b0;
    edges(10);
    chk("R4", "csec gated base tick", csec_o, 8'h01);
    base_tick_i = 1'b1;
    edges(9 * DIV);
    chk("R4", "csec bcd 10", csec_o, 8'h10);
    // mid-count write restarts the second
    wr(3'd2, 8'h11);
    chk("R3", "csec cleared by write", csec_o, 8'h00);
    edges(SEC_EDGES - 1);
    chk("R3", "sec not yet stepped", {1'b0, sec_o}, 8'h42);
    edges(1);
    chk("R5", "sec step after 99 wrap", {1'b0, sec_o}, 8'h43);
    chk("R5", "csec wrapped", csec_o, 8'h00);
  endtask

  task automatic t_year_roll(input logic cen, input logic c0, input logic exp_c);
    base_tick_i = 1'b1;
    set_all(8'h99, 8'h12, 8'h31, 8'h07, {cen, c0, 6'h23}, 8'h59, 8'h59);
    edges(SEC_EDGES - 1);
    chk("R5", "sec before roll", {1'b0, sec_o}, 8'h59);
    edges(1);
    chk("R5", "sec", {1'b0, sec_o}, 8'h00);
    chk("R5", "min", {1'b0, min_o}, 8'h00);
    chk("R5", "hour", {2'b0, hour_o}, 8'h00);
    chk("R6", "dow wrap", {5'b0, dow_o}, 8'h01);
    chk("R8", "date", {2'b0, date_o}, 8'h01);
    chk("R8", "month wrap", {3'b0, month_o}, 8'h01);
    chk("R8", "year wrap", year_o, 8'h00);
    chk("R9", "century", {7'b0, cent_o}, {7'b0, exp_c});
    chk("R9", "century enable", {7'b0, cent_en_o}, {7'b0, cen});
  endtask

  task automatic t_month_end(input logic [7:0] yr, mo, dt, exp_mo, exp_dt);
    base_tick_i = 1'b1;
    set_all(yr, mo, dt, 8'h03, 8'h23, 8'h59, 8'h59);
    edges(SEC_EDGES);
    chk("R7", "date", {2'b0, date_o}, exp_dt);
    chk("R7", "month", {3'b0, month_o}, exp_mo);
    chk("R6", "dow step", {5'b0, dow_o}, 8'h04);
  endtask

  task automatic t_stop;
    base_tick_i = 1'b1;
    wr(3'd1, 8'h85);
    chk("R2", "stop set", {7'b0, stop_o}, 8'h01);
    edges(3 * SEC_EDGES);
    chk("R10", "sec frozen", {1'b0, sec_o}, 8'h05);
    chk("R10", "csec frozen", csec_o, 8'h00);
    wr(3'd2, 8'h20);
    edges(SEC_EDGES);
    chk("R10", "sec frozen after other write", {1'b0, sec_o}, 8'h05);
    wr(3'd1, 8'h05);
    chk("R10", "stop cleared", {7'b0, stop_o}, 8'h00);
    edges(SEC_EDGES - 1);
    chk("R10", "sec before restart step", {1'b0, sec_o}, 8'h05);
    edges(1);
    chk("R10", "sec restart step", {1'b0, sec_o}, 8'h06);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    edges(3);
    t_reset();
    rst_ni = 1'b1;
    edges(2);
    t_reset();
    t_write_fields();
    t_prescale();
    t_year_roll(1'b1, 1'b0, 1'b1);
    t_year_roll(1'b0, 1'b1, 1'b1);
    t_year_roll(1'b1, 1'b1, 1'b0);
    t_month_end(8'h23, 8'h02, 8'h28, 8'h03, 8'h01);
    t_month_end(8'h24, 8'h02, 8'h28, 8'h02, 8'h29);
    t_month_end(8'h24, 8'h02, 8'h29, 8'h03, 8'h01);
    t_month_end(8'h12, 8'h02, 8'h28, 8'h02, 8'h29);
    t_month_end(8'h10, 8'h02, 8'h28, 8'h03, 8'h01);
    t_month_end(8'h05, 8'h04, 8'h30, 8'h05, 8'h01);
    t_month_end(8'h05, 8'h01, 8'h30, 8'h01, 8'h31);
    t_month_end(8'h05, 8'h07, 8'h31, 8'h08, 8'h01);
    t_stop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule